// File: doc/BRIEF.md
# All-Digital First-Order Phase-Locked Loop Core

This block holds everything a first-order digital phase-locked loop needs except the feedback divider. It compares a reference input with a feedback input in two ways: an exclusive-OR detector whose duty cycle tracks the phase difference, and an edge-triggered detector that latches high on a reference rising edge and low on a feedback rising edge. One of the two detector outputs sets the direction of a loop-filter counter. That counter is an up/down counter whose length is chosen at run time by a 4-bit code. When it wraps past its top it emits a one-cycle carry, and when it wraps below zero it emits a one-cycle borrow.

Carries and borrows steer a pulse-shaping stage. Left alone, this stage produces a square wave at half the rate of its half-period timebase. Each correction moves the next output edge one timebase step earlier (carry) or later (borrow). An external divide-by-N counter closes the loop by feeding the output back to the feedback input. The loop centre frequency is then the correction clock divided by 2N.

Everything runs on a single clock. The counter timebase and the correction timebase are clock enables (`k_en`, `id_en`), and each `id_en` strike stands for one half-period of the correction clock. The reference and feedback inputs are sampled on that same clock.

Top module: `dpll_core`

## Requirements
- R1: `xor_out` equals `ref_in` XOR `fb_in` at all times, with no register in the path.
- R2: `ecpd_out` is registered. It goes to 1 the cycle after a sampled rising edge of `ref_in` with no rising edge of `fb_in`. It goes to 0 the cycle after a rising edge of `fb_in` with no rising edge of `ref_in`. Otherwise, including when both inputs rise together, it holds.
- R3: `det_sel` = 0 steers the counter with `xor_out` and `det_sel` = 1 steers it with `ecpd_out`. A 1 on the chosen detector counts up and a 0 counts down, on each cycle with `k_en` high.
- R4: For a code c from 1 to 15, the counter has c+2 stages and modulus 2^(c+2). Starting from a cleared counter, the first carry comes on the 2^(c+2)-th up tick.
- R5: Carry and borrow are each high for exactly one cycle, namely the cycle after the tick that wraps the counter. A wrap reloads the midpoint 2^(c+1). From the midpoint, the next carry comes after 2^(c+1) up ticks and the next borrow after 2^(c+1)+1 down ticks. Carry and borrow are never high together.
- R6: Code 0 freezes the counter at its present value and suppresses carry and borrow.
- R7: A code change needs no reset. The next tick acts on the stored value reduced modulo the new modulus.
- R8: With no corrections pending, `id_out` toggles on every second `id_en` strike. After reset the first toggle comes on the second strike, and `id_out` never changes on a cycle without a strike.
- R9: A pending carry makes the next strike toggle `id_out` without advancing the divide-by-2 phase, which moves later edges one strike earlier. A pending borrow makes the next strike do nothing, which moves later edges one strike later. If both are pending, they cancel and the strike behaves normally.
- R10: A correction is applied at most once. Several carries that arrive before the next strike count as one.
- R11: Reset clears the counter, the pending corrections, the detector state, `id_out`, `carry` and `borrow`.
- R12: With a divide-by-8 feedback divider and a reference at the centre frequency, the XOR detector settles to a duty cycle between 40 and 60 percent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_in | input | 1 | Reference signal, sampled on `clk` |
| fb_in | input | 1 | Feedback signal from the external divider |
| det_sel | input | 1 | 0 selects XOR detector, 1 selects edge detector for direction |
| len_code | input | 4 | Counter length code; 0 disables, c gives c+2 stages |
| k_en | input | 1 | Counter timebase strike |
| id_en | input | 1 | Correction timebase strike, one per half-period of the correction clock |
| xor_out | output | 1 | Exclusive-OR detector output |
| ecpd_out | output | 1 | Edge-triggered detector output |
| carry | output | 1 | One-cycle overflow pulse |
| borrow | output | 1 | One-cycle underflow pulse |
| id_out | output | 1 | Corrected output square wave |

## Verification
The hardest state to reach from the ports is a correction that waits while the counter keeps producing pulses. This covers a carry and a borrow pending at once, and two carries that land before one timebase strike. The bench reaches these states by holding `id_en` low while it strikes `k_en` across one or two wraps, and by flipping the reference level between the wraps. Only then does it release single `id_en` strikes and compare each edge against the undisturbed divide-by-2 pattern. The closed-loop duty check starts the feedback in phase with the reference, the unstable zero-duty point, so the loop has to drift a quarter period through repeated borrows.

// File: rtl/dpll_pkg.sv
`timescale 1ns/1ps
package dpll_pkg;
  localparam int unsigned LEN_CODE_W = 4;
  localparam int unsigned KCNT_W     = 17;
  localparam int unsigned STAGE_BASE = 2;
  localparam int unsigned RST_STAGES = 2;

  typedef enum logic {
    DET_XOR  = 1'b0,
    DET_EDGE = 1'b1
  } det_sel_e;
endpackage

// File: rtl/dpll_rst_sync.sv
`timescale 1ns/1ps
module dpll_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dpll_phase_det.sv
`timescale 1ns/1ps
module dpll_phase_det
  import dpll_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ref_in,
  input  logic     fb_in,
  input  det_sel_e sel,
  output logic     xor_out,
  output logic     edge_out,
  output logic     dir_up
);
  logic ref_d_q, fb_d_q, edge_q;
  logic edge_d;
  logic ref_rise, fb_rise;

  assign ref_rise = ref_in & ~ref_d_q;
  assign fb_rise  = fb_in  & ~fb_d_q;
  assign xor_out  = ref_in ^ fb_in;

  always_comb begin
    edge_d = edge_q;
    if (ref_rise && !fb_rise)      edge_d = 1'b1;
    else if (fb_rise && !ref_rise) edge_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d_q <= 1'b0;
      fb_d_q  <= 1'b0;
      edge_q  <= 1'b0;
    end else begin
      ref_d_q <= ref_in;
      fb_d_q  <= fb_in;
      edge_q  <= edge_d;
    end
  end

  assign edge_out = edge_q;
  assign dir_up   = (sel == DET_EDGE) ? edge_q : xor_out;
endmodule

// File: rtl/dpll_kcounter.sv
`timescale 1ns/1ps
module dpll_kcounter #(
  parameter int unsigned CNT_W      = 17,
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned STAGE_BASE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              up,
  input  logic [CODE_W-1:0] code,
  output logic              carry,
  output logic              borrow
);
  localparam int unsigned STG_W = CODE_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             carry_q, carry_d, borrow_q, borrow_d;
  logic [STG_W-1:0] stages;
  logic [CNT_W-1:0] mask, mid, masked;
  logic             active;

  assign stages = {1'b0, code} + STG_W'(STAGE_BASE);
  assign active = (code != '0);

  for (genvar b = 0; b < CNT_W; b++) begin : g_mask
    assign mask[b] = (b < int'(stages));
  end

  assign mid    = (mask >> 1) + CNT_W'(1);
  assign masked = cnt_q & mask;

  always_comb begin
    cnt_d    = cnt_q;
    carry_d  = 1'b0;
    borrow_d = 1'b0;
    if (tick && active) begin
      if (up) begin
        if (masked == mask) begin
          carry_d = 1'b1;
          cnt_d   = mid;
        end else begin
          cnt_d = masked + CNT_W'(1);
        end
      end else begin
        if (masked == '0) begin
          borrow_d = 1'b1;
          cnt_d    = mid;
        end else begin
          cnt_d = masked - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      carry_q  <= 1'b0;
      borrow_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      carry_q  <= carry_d;
      borrow_q <= borrow_d;
    end
  end

  assign carry  = carry_q;
  assign borrow = borrow_q;
endmodule

// File: rtl/dpll_id_circuit.sv
`timescale 1ns/1ps
module dpll_id_circuit (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic carry_in,
  input  logic borrow_in,
  output logic out
);
  logic out_q, out_d;
  logic ph_q, ph_d;
  logic adv_q, adv_d;
  logic ret_q, ret_d;

  always_comb begin
    out_d = out_q;
    ph_d  = ph_q;
    adv_d = adv_q;
    ret_d = ret_q;
    if (tick) begin
      adv_d = 1'b0;
      ret_d = 1'b0;
      if (adv_q && !ret_q) begin
        out_d = ~out_q;
      end else if (ret_q && !adv_q) begin
        out_d = out_q;
      end else begin
        ph_d = ~ph_q;
        if (ph_q) out_d = ~out_q;
      end
    end
    if (carry_in)  adv_d = 1'b1;
    if (borrow_in) ret_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      ph_q  <= 1'b0;
      adv_q <= 1'b0;
      ret_q <= 1'b0;
    end else begin
      out_q <= out_d;
      ph_q  <= ph_d;
      adv_q <= adv_d;
      ret_q <= ret_d;
    end
  end

  assign out = out_q;
endmodule

// File: rtl/dpll_core.sv
`timescale 1ns/1ps
module dpll_core
  import dpll_pkg::*;
#(
  parameter int unsigned CODE_W = LEN_CODE_W,
  parameter int unsigned CNT_W  = KCNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic              fb_in,
  input  logic              det_sel,
  input  logic [CODE_W-1:0] len_code,
  input  logic              k_en,
  input  logic              id_en,
  output logic              xor_out,
  output logic              ecpd_out,
  output logic              carry,
  output logic              borrow,
  output logic              id_out
);
  logic     rst_q_n;
  logic     dir_up;
  det_sel_e sel_e;

  assign sel_e = det_sel_e'(det_sel);

  dpll_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_q_n)
  );

  dpll_phase_det u_pd (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .ref_in  (ref_in),
    .fb_in   (fb_in),
    .sel     (sel_e),
    .xor_out (xor_out),
    .edge_out(ecpd_out),
    .dir_up  (dir_up)
  );

  dpll_kcounter #(
    .CNT_W     (CNT_W),
    .CODE_W    (CODE_W),
    .STAGE_BASE(STAGE_BASE)
  ) u_kcnt (
    .clk   (clk),
    .rst_n (rst_q_n),
    .tick  (k_en),
    .up    (dir_up),
    .code  (len_code),
    .carry (carry),
    .borrow(borrow)
  );

  dpll_id_circuit u_id (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .tick     (id_en),
    .carry_in (carry),
    .borrow_in(borrow),
    .out      (id_out)
  );
endmodule

// File: rtl/dpll_core_checker.sv
`timescale 1ns/1ps
module dpll_core_checker #(
  parameter int unsigned CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_in,
  input logic              fb_in,
  input logic [CODE_W-1:0] len_code,
  input logic              k_en,
  input logic              id_en,
  input logic              carry,
  input logic              borrow,
  input logic              ecpd_out,
  input logic              id_out
);
  a_r5_carry_single: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> !carry);

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry && borrow));

  a_r4_carry_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (carry || borrow) |-> $past(k_en));

  a_r6_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(len_code) == '0) |-> (!carry && !borrow));

  a_r8_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(id_en) |-> $stable(id_out));

  a_r2_edge_set: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ref_in) && !$rose(fb_in)) |=> ecpd_out);

  a_r2_edge_clr: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fb_in) && !$rose(ref_in)) |=> !ecpd_out);
endmodule

bind dpll_core dpll_core_checker #(.CODE_W(CODE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .ref_in  (ref_in),
  .fb_in   (fb_in),
  .len_code(len_code),
  .k_en    (k_en),
  .id_en   (id_en),
  .carry   (carry),
  .borrow  (borrow),
  .ecpd_out(ecpd_out),
  .id_out  (id_out)
);

// File: tb/dpll_core_bench.sv
`timescale 1ns/1ps
module dpll_core_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tb_ref, tb_fb, det_sel, k_en, id_en;
  logic [3:0] len_code;
  logic       ref_in, fb_in;
  logic       xor_out, ecpd_out, carry, borrow, id_out;

  logic loop_on = 1'b0;
  logic loop_ref = 1'b0;
  logic loop_fb = 1'b0;
  logic id_prev = 1'b0;
  int   ref_cnt = 0;
  int   div_cnt = 0;

  int checks = 0;
  int errors = 0;

  // code, first carry tick from clear, next carry from midpoint, borrow from midpoint
  localparam int TAB_N = 6;
  localparam int TAB [TAB_N][4] = '{
    '{1,   8,   4,   5},
    '{2,  16,   8,   9},
    '{3,  32,  16,  17},
    '{4,  64,  32,  33},
    '{5, 128,  64,  65},
    '{6, 256, 128, 129}
  };

  always #2 clk = ~clk;

  assign ref_in = loop_on ? loop_ref : tb_ref;
  assign fb_in  = loop_on ? loop_fb  : tb_fb;

  dpll_core u_dpll_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_in  (ref_in),
    .fb_in   (fb_in),
    .det_sel (det_sel),
    .len_code(len_code),
    .k_en    (k_en),
    .id_en   (id_en),
    .xor_out (xor_out),
    .ecpd_out(ecpd_out),
    .carry   (carry),
    .borrow  (borrow),
    .id_out  (id_out)
  );

  // reference at the centre frequency and divide-by-8 feedback, both on the falling edge
  always @(negedge clk) begin
    if (loop_on) begin
      ref_cnt = ref_cnt + 1;
      if (ref_cnt == 16) begin
        ref_cnt  = 0;
        loop_ref = ~loop_ref;
      end
      if (id_out && !id_prev) begin
        div_cnt = div_cnt + 1;
        if (div_cnt == 4) begin
          div_cnt = 0;
          loop_fb = ~loop_fb;
        end
      end
      id_prev = id_out;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tb_ref = 1'b0; tb_fb = 1'b0; det_sel = 1'b0;
    k_en = 1'b0; id_en = 1'b0; len_code = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic k_ticks(input int n, output int nc, output int fc,
                         output int nb, output int fbw);
    nc = 0; fc = 0; nb = 0; fbw = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); k_en = 1'b1;
      @(posedge clk); #1;
      k_en = 1'b0;
      if (carry)  begin nc++; if (fc == 0)  fc = i;  end
      if (borrow) begin nb++; if (fbw == 0) fbw = i; end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic id_step();
    @(negedge clk); id_en = 1'b1;
    @(posedge clk); #1;
    id_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  initial begin
    int nc, fc, nb, fbw, hi;

    // R11: reset state
    do_reset();
    chk(ecpd_out == 1'b0, "R11", "ecpd after reset", ecpd_out, 0);
    chk(carry == 1'b0 && borrow == 1'b0, "R11", "pulses after reset", carry + borrow, 0);
    chk(id_out == 1'b0, "R11", "id_out after reset", id_out, 0);

    // R1: XOR detector over all input pairs
    for (int v = 0; v < 4; v++) begin
      @(negedge clk); tb_ref = v[1]; tb_fb = v[0];
      #1 chk(xor_out == (v[1] ^ v[0]), "R1", "xor", xor_out, v[1] ^ v[0]);
    end

    // R2: edge detector
    do_reset();
    @(negedge clk); tb_ref = 1'b1;
    @(posedge clk); #1 chk(ecpd_out == 1'b1, "R2", "set on ref rise", ecpd_out, 1);
    @(negedge clk); tb_fb = 1'b1;
    @(posedge clk); #1 chk(ecpd_out == 1'b0, "R2", "clear on fb rise", ecpd_out, 0);
    @(negedge clk); tb_ref = 1'b0; tb_fb = 1'b0;
    @(negedge clk); tb_ref = 1'b1; tb_fb = 1'b1;
    step(); chk(ecpd_out == 1'b0, "R2", "hold low on joint rise", ecpd_out, 0);
    @(negedge clk); tb_ref = 1'b0; tb_fb = 1'b0;
    @(negedge clk); tb_ref = 1'b1;
    @(negedge clk); tb_ref = 1'b0;
    @(negedge clk); tb_ref = 1'b1; tb_fb = 1'b1;
    step(); chk(ecpd_out == 1'b1, "R2", "hold high on joint rise", ecpd_out, 1);

    // R4 / R5: table of length codes walked by one loop
    for (int e = 0; e < TAB_N; e++) begin
      do_reset();
      len_code = 4'(TAB[e][0]);
      @(negedge clk); tb_ref = 1'b1;
      k_ticks(TAB[e][1], nc, fc, nb, fbw);
      chk(fc == TAB[e][1] && nc == 1, "R4", $sformatf("first carry code %0d", TAB[e][0]), fc, TAB[e][1]);
      k_ticks(TAB[e][2], nc, fc, nb, fbw);
      chk(fc == TAB[e][2] && nc == 1, "R5", $sformatf("carry from midpoint code %0d", TAB[e][0]), fc, TAB[e][2]);
      @(negedge clk); tb_ref = 1'b0;
      k_ticks(TAB[e][3], nc, fc, nb, fbw);
      chk(fbw == TAB[e][3] && nb == 1 && nc == 0, "R5", $sformatf("borrow from midpoint code %0d", TAB[e][0]), fbw, TAB[e][3]);
    end

    // R5: the longest setting must stay silent well short of its modulus
    do_reset();
    len_code = 4'd15;
    @(negedge clk); tb_ref = 1'b1;
    k_ticks(1000, nc, fc, nb, fbw);
    chk(nc == 0 && nb == 0, "R5", "17-stage no early wrap", nc + nb, 0);

    // R6: code 0 freezes the counter
    do_reset();
    @(negedge clk); tb_ref = 1'b1;
    k_ticks(20, nc, fc, nb, fbw);
    chk(nc == 0 && nb == 0, "R6", "disabled up", nc + nb, 0);
    @(negedge clk); tb_ref = 1'b0;
    k_ticks(5, nc, fc, nb, fbw);
    chk(nc == 0 && nb == 0, "R6", "disabled down", nc + nb, 0);
    len_code = 4'd1;
    @(negedge clk); tb_ref = 1'b1;
    k_ticks(8, nc, fc, nb, fbw);
    chk(fc == 8, "R6", "count held at zero", fc, 8);

    // R7: live length change keeps low bits
    do_reset();
    len_code = 4'd3;
    @(negedge clk); tb_ref = 1'b1;
    k_ticks(21, nc, fc, nb, fbw);
    chk(nc == 0, "R7", "no carry before change", nc, 0);
    len_code = 4'd1;
    k_ticks(4, nc, fc, nb, fbw);
    chk(fc == 3, "R7", "carry after truncation", fc, 3);

    // R3: detector selection
    do_reset();
    len_code = 4'd1; det_sel = 1'b1;
    @(negedge clk); tb_fb = 1'b1;
    k_ticks(1, nc, fc, nb, fbw);
    chk(nb == 1, "R3", "edge detector low counts down", nb, 1);
    do_reset();
    len_code = 4'd1; det_sel = 1'b0;
    @(negedge clk); tb_fb = 1'b1;
    k_ticks(1, nc, fc, nb, fbw);
    chk(nb == 0, "R3", "xor high counts up", nb, 0);

    // R8: undisturbed divide-by-2
    do_reset();
    for (int t = 1; t <= 6; t++) begin
      id_step();
      chk(id_out == ((t / 2) % 2), "R8", $sformatf("id_out after strike %0d", t), id_out, (t / 2) % 2);
    end

    // R9: carry advances
    do_reset();
    len_code = 4'd1;
    @(negedge clk); tb_ref = 1'b1;
    k_ticks(8, nc, fc, nb, fbw);
    id_step(); chk(id_out == 1'b1, "R9", "carry toggles on first strike", id_out, 1);
    id_step(); id_step();
    chk(id_out == 1'b0, "R9", "phase kept after carry", id_out, 0);

    // R9: borrow retards
    do_reset();
    len_code = 4'd1;
    k_ticks(1, nc, fc, nb, fbw);
    id_step(); id_step();
    chk(id_out == 1'b0, "R9", "borrow delays edge", id_out, 0);
    id_step();
    chk(id_out == 1'b1, "R9", "edge one strike late", id_out, 1);

    // R9: carry and borrow both pending cancel
    do_reset();
    len_code = 4'd1;
    k_ticks(1, nc, fc, nb, fbw);
    @(negedge clk); tb_ref = 1'b1;
    k_ticks(4, nc, fc, nb, fbw);
    id_step();
    chk(id_out == 1'b0, "R9", "cancel first strike", id_out, 0);
    id_step();
    chk(id_out == 1'b1, "R9", "cancel second strike", id_out, 1);

    // R10: two carries before a strike count once
    do_reset();
    len_code = 4'd1;
    @(negedge clk); tb_ref = 1'b1;
    k_ticks(12, nc, fc, nb, fbw);
    chk(nc == 2, "R10", "two carries produced", nc, 2);
    id_step();
    id_step();
    chk(id_out == 1'b1, "R10", "single correction applied", id_out, 1);

    // R11: reset after activity clears the counter
    rst_n = 1'b0;
    @(negedge clk);
    #1 chk(id_out == 1'b0 && ecpd_out == 1'b0, "R11", "async clear", id_out + ecpd_out, 0);
    do_reset();
    len_code = 4'd1;
    @(negedge clk); tb_ref = 1'b1;
    k_ticks(8, nc, fc, nb, fbw);
    chk(fc == 8, "R11", "counter cleared", fc, 8);

    // R12: closed loop at centre frequency
    do_reset();
    len_code = 4'd2; det_sel = 1'b0;
    @(negedge clk);
    loop_on = 1'b1; k_en = 1'b1; id_en = 1'b1;
    repeat (3000) @(negedge clk);
    hi = 0;
    for (int i = 0; i < 640; i++) begin
      @(posedge clk); #1;
      if (xor_out) hi++;
    end
    chk(hi >= 256 && hi <= 384, "R12", "xor duty high count of 640", hi, 320);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule